// File: doc/BRIEF.md
# Host Slave Port with Indirect Register Window

This block is the asynchronous, SRAM-style slave port through which a host processor configures a codec-class device and moves its data streams. The host drives active-low chip select, read and write strobes with a 4-bit address. Two flops synchronise these strobes into the port's clock domain. Each access takes effect when its strobe is released. Only sixteen locations can be addressed directly. All other registers are reached through an address pointer and a data window. The pointer steps forward after every completed window access, so a run of neighbouring registers can be moved without rewriting it.

Register traffic and stream traffic have separate width settings. The control path is 16 or 32 bits wide and the data path is 8, 16 or 32 bits wide. Any value narrower than the bus sits at the top of the bus. A 32-bit word is split over several bus cycles, most significant part first. Stream cycles are marked by a DMA acknowledge input. In fly-by mode the two strobes swap roles for those cycles only. The host can then pair a device read with a memory write on one strobe during encoding, or pair a memory read with a device write during decoding.

Top module: `hb_port`

## Requirements
- R1: After reset, rdata is zero, dma_in_valid and dma_out_take are low, and the indirect address pointer reads back as zero.
- R2: Address 0 is the indirect address pointer (read and write) and address 1 is the indirect data window. A write to any other address changes no state, and a read from any other address returns zero.
- R3: A window access reaches the register selected by the pointer. The pointer increments by one, wrapping at the register count, after the final beat of each window read or write. A window write stores the whole assembled 32-bit word.
- R4: With ctl_wide=1, register values use all 32 data bits and take one beat. With ctl_wide=0, register values travel on bits 31:16 with bits 15:0 reading zero: the pointer is one beat, and a window word takes two beats with the upper half first.
- R5: Strobes pass through a two-flop synchroniser, and a write takes the value on wdata at the moment its released strobe is detected. Data changed while the strobe is still held therefore replaces the earlier value.
- R6: data_size selects the stream beat width (0: 8 bits, 1: 16 bits, 2 or 3: 32 bits). A word moves in 4, 2 or 1 beats, most significant part first, on the top bits of the bus with unused low bits reading zero. dma_out_take pulses for one cycle after the last outbound beat. dma_in_valid pulses for one cycle with the assembled word after the last inbound beat.
- R7: While dack_n is low and flyby=0, rd_n fetches outbound stream data and wr_n delivers inbound data. With flyby=1 these roles are swapped. Accesses made without dack_n keep the normal strobe meaning in both modes.
- R8: When cs_n and dack_n are both low, the cycle is served as a stream transfer and the register access is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low register select, asynchronous |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| dack_n | input | 1 | Active-low stream transfer acknowledge, asynchronous |
| addr | input | 4 | Direct register address |
| wdata | input | 32 | Host write bus, MSB-justified |
| rdata | output | 32 | Host read bus, MSB-justified |
| ctl_wide | input | 1 | Control path width: 1 = 32 bits, 0 = 16 bits |
| data_size | input | 2 | Stream beat width select |
| flyby | input | 1 | Swap strobe roles for stream cycles |
| dma_out_word | input | 32 | Next outbound stream word from the device |
| dma_out_take | output | 1 | Outbound word consumed |
| dma_in_word | output | 32 | Assembled inbound stream word |
| dma_in_valid | output | 1 | Inbound word complete |

## Verification
Two functions can fall in the same cycle: a register access and a stream transfer, when chip select and DMA acknowledge are held low together around a single write strobe. The bench provokes this by holding both selects while pulsing wr_n over a 32-bit stream beat that carries a value which would also be a legal pointer. The outcome is judged at the ports. The delivered inbound word must equal the bus value, and the pointer, read back afterwards, must still hold its earlier value. A second overlap lies inside the pointer itself: the final window beat both stores the word and advances the pointer. A read of address 0 right after each write, and read-back bursts over several registers, show that the store used the old pointer and the next access used the new one.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        SRC_ZERO   = 2'd0,
        SRC_IADDR  = 2'd1,
        SRC_WIN    = 2'd2,
        SRC_STREAM = 2'd3
    } rd_src_e;

    localparam logic [3:0] LOC_IADDR  = 4'h0;
    localparam logic [3:0] LOC_WINDOW = 4'h1;

    // bus beat width in bits for a size code
    function automatic logic [5:0] lane_bits(input logic [1:0] size);
        case (size)
            2'd0:    lane_bits = 6'd8;
            2'd1:    lane_bits = 6'd16;
            default: lane_bits = 6'd32;
        endcase
    endfunction

    // index of the final beat of a 32-bit word
    function automatic logic [1:0] last_beat(input logic [1:0] size);
        case (size)
            2'd0:    last_beat = 2'd3;
            2'd1:    last_beat = 2'd1;
            default: last_beat = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.s2;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R5: a synchronised level only rises two edges after the pin
        a_r5_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lvl[i]) |-> $past(raw[i], 2));
    end

endmodule

// File: rtl/hb_pack.sv
module hb_pack
    import hb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  size,
    input  logic        ld,
    input  logic [31:0] ld_word,
    input  logic        rd_beat,
    input  logic        wr_beat,
    input  logic [31:0] bus_in,
    output logic [31:0] lane,
    output logic [31:0] word,
    output logic        fin
);

    typedef struct packed {
        logic [1:0]  cnt;
        logic [31:0] sh;
    } pack_t;

    pack_t st_d, st_q;

    logic [5:0]  w;
    logic        last;
    logic [31:0] shifted;
    logic [31:0] incoming;

    always_comb begin
        w        = lane_bits(size);
        last     = (st_q.cnt == last_beat(size));
        shifted  = st_q.sh << w;
        incoming = bus_in >> (6'd32 - w);
        word     = shifted | incoming;
        lane     = st_q.sh & (32'hFFFF_FFFF << (6'd32 - w));
        fin      = (rd_beat | wr_beat) & last;

        st_d = st_q;
        if (ld && st_q.cnt == 2'd0) st_d.sh = ld_word;
        if (rd_beat) begin
            st_d.sh  = shifted;
            st_d.cnt = last ? 2'd0 : st_q.cnt + 2'd1;
        end else if (wr_beat) begin
            st_d.sh  = word;
            st_d.cnt = last ? 2'd0 : st_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: after the final beat of a word the beat counter is back at zero
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (st_q.cnt == 2'd0));

endmodule

// File: rtl/hb_regs.sv
module hb_regs #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);

    logic [31:0] mem_d [DEPTH];
    logic [31:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

    // R3: a committed window write lands at the pointed entry
    a_r3_store: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/hb_port.sv
module hb_port
    import hb_pkg::*;
#(
    parameter int REG_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        dack_n,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        ctl_wide,
    input  logic [1:0]  data_size,
    input  logic        flyby,
    input  logic [31:0] dma_out_word,
    output logic        dma_out_take,
    output logic [31:0] dma_in_word,
    output logic        dma_in_valid
);

    localparam int AW = $clog2(REG_DEPTH);

    typedef struct packed {
        logic [1:0]    prev;      // delayed rd/wr levels
        logic [AW-1:0] ia;
        rd_src_e       rsel;
        logic          in_valid;
        logic [31:0]   in_word;
    } port_t;

    port_t st_d, st_q;

    // bit 0 cs, 1 rd, 2 wr, 3 dack (active high after inversion)
    logic [3:0] lvl;

    hb_sync #(.N(4)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({~dack_n, ~wr_n, ~rd_n, ~cs_n}),
        .lvl   (lvl)
    );

    logic rd_rise, rd_fall, wr_rise, wr_fall;
    logic dma_on, reg_on;
    logic get_start, get_end, put_end;
    logic reg_rd_start, reg_rd_end, reg_wr_end;
    logic hit_ia, hit_win;

    always_comb begin
        rd_rise = lvl[1] & ~st_q.prev[0];
        rd_fall = ~lvl[1] & st_q.prev[0];
        wr_rise = lvl[2] & ~st_q.prev[1];
        wr_fall = ~lvl[2] & st_q.prev[1];
        dma_on  = lvl[3];
        reg_on  = lvl[0] & ~lvl[3];
        get_start    = dma_on & (flyby ? wr_rise : rd_rise);
        get_end      = dma_on & (flyby ? wr_fall : rd_fall);
        put_end      = dma_on & (flyby ? rd_fall : wr_fall);
        reg_rd_start = reg_on & rd_rise;
        reg_rd_end   = reg_on & rd_fall;
        reg_wr_end   = reg_on & wr_fall;
        hit_ia  = (addr == LOC_IADDR);
        hit_win = (addr == LOC_WINDOW);
    end

    logic [31:0] rf_rdata;
    logic [31:0] c_lane, c_word, d_lane, d_word;
    logic        c_fin, d_fin;
    logic        rf_we;

    hb_pack i_ctl_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .size    (ctl_wide ? 2'd2 : 2'd1),
        .ld      (reg_rd_start & hit_win),
        .ld_word (rf_rdata),
        .rd_beat (reg_rd_end & hit_win),
        .wr_beat (reg_wr_end & hit_win),
        .bus_in  (wdata),
        .lane    (c_lane),
        .word    (c_word),
        .fin     (c_fin)
    );

    hb_pack i_dma_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .size    (data_size),
        .ld      (get_start),
        .ld_word (dma_out_word),
        .rd_beat (get_end),
        .wr_beat (put_end),
        .bus_in  (wdata),
        .lane    (d_lane),
        .word    (d_word),
        .fin     (d_fin)
    );

    assign rf_we = c_fin & reg_wr_end & hit_win;

    hb_regs #(.DEPTH(REG_DEPTH)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (st_q.ia),
        .wdata (c_word),
        .raddr (st_q.ia),
        .rdata (rf_rdata)
    );

    always_comb begin
        st_d          = st_q;
        st_d.prev     = lvl[2:1];
        st_d.in_valid = 1'b0;
        if (reg_rd_start) begin
            if (hit_ia)       st_d.rsel = SRC_IADDR;
            else if (hit_win) st_d.rsel = SRC_WIN;
            else              st_d.rsel = SRC_ZERO;
        end
        if (get_start) st_d.rsel = SRC_STREAM;
        if (reg_wr_end && hit_ia)
            st_d.ia = ctl_wide ? wdata[AW-1:0] : wdata[16 +: AW];
        if (c_fin && hit_win) st_d.ia = st_q.ia + AW'(1);
        if (d_fin && put_end) begin
            st_d.in_valid = 1'b1;
            st_d.in_word  = d_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: '0, ia: '0, rsel: SRC_ZERO, in_valid: 1'b0, in_word: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        case (st_q.rsel)
            SRC_IADDR:  rdata = ctl_wide ? 32'(st_q.ia) : {16'(st_q.ia), 16'h0};
            SRC_WIN:    rdata = c_lane;
            SRC_STREAM: rdata = d_lane;
            default:    rdata = '0;
        endcase
    end

    assign dma_out_take = d_fin & get_end;
    assign dma_in_word  = st_q.in_word;
    assign dma_in_valid = st_q.in_valid;

    // R2: writes to unmapped direct locations leave the pointer alone
    a_r2_unmapped_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_end && !hit_ia && !hit_win) |=> $stable(st_q.ia));

    // R3: the pointer steps by one after a completed window word
    a_r3_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
        c_fin |=> (st_q.ia == AW'($past(st_q.ia) + AW'(1))));

    // R8: a write strobe with both selects held is not a register write
    a_r8_dma_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[3] && lvl[0] && wr_fall) |=> $stable(st_q.ia));

    // R6: inbound completion is a single-cycle pulse
    a_r6_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dma_in_valid |=> !dma_in_valid);

    // R7: outbound words are only consumed under an acknowledge
    a_r7_take_under_ack: assert property (@(posedge clk) disable iff (!rst_n)
        dma_out_take |-> !$past(dack_n, 2));

endmodule

// File: tb/test_hb_port.sv
module test_hb_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, dack_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ctl_wide = 1'b1;
    logic [1:0]  data_size = 2'd2;
    logic        flyby = 1'b0;
    logic [31:0] dma_out_word = '0;
    logic        dma_out_take;
    logic [31:0] dma_in_word;
    logic        dma_in_valid;

    int n_chk = 0;
    int n_fail = 0;
    int takes = 0;
    int ins = 0;
    logic [31:0] in_last = '0;

    always #10 clk = ~clk;

    hb_port i_hb_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .dack_n(dack_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ctl_wide(ctl_wide), .data_size(data_size), .flyby(flyby),
        .dma_out_word(dma_out_word), .dma_out_take(dma_out_take),
        .dma_in_word(dma_in_word), .dma_in_valid(dma_in_valid)
    );

    always @(posedge clk) begin
        if (dma_out_take) takes <= takes + 1;
        if (dma_in_valid) begin
            ins     <= ins + 1;
            in_last <= dma_in_word;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0;
        wait_n(2); wr_n = 1'b0;
        wait_n(5); wr_n = 1'b1;
        wait_n(5); cs_n = 1'b1;
        wait_n(3);
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; cs_n = 1'b0;
        wait_n(2); rd_n = 1'b0;
        wait_n(5); d = rdata;
        rd_n = 1'b1;
        wait_n(5); cs_n = 1'b1;
        wait_n(3);
    endtask

    function automatic logic [31:0] ia_bus(input logic wide, input logic [5:0] ia);
        return wide ? {26'h0, ia} : {10'h0, ia, 16'h0};
    endfunction

    task automatic set_ia(input logic [5:0] ia);
        bus_write(4'h0, ia_bus(ctl_wide, ia));
    endtask

    task automatic win_write(input logic [31:0] v);
        if (ctl_wide) bus_write(4'h1, v);
        else begin
            bus_write(4'h1, {v[31:16], 16'h0});
            bus_write(4'h1, {v[15:0], 16'h0});
        end
    endtask

    task automatic win_read(output logic [31:0] v);
        logic [31:0] b0, b1;
        if (ctl_wide) bus_read(4'h1, v);
        else begin
            bus_read(4'h1, b0);
            bus_read(4'h1, b1);
            check("R4 low half zero", {b0[15:0], b1[15:0]}, 32'h0);
            v = {b0[31:16], b1[31:16]};
        end
    endtask

    // one stream beat; use_wr picks which pin pulses
    task automatic dma_beat(input logic use_wr, input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        wdata = d; dack_n = 1'b0;
        wait_n(2);
        if (use_wr) wr_n = 1'b0; else rd_n = 1'b0;
        wait_n(5); q = rdata;
        wr_n = 1'b1; rd_n = 1'b1;
        wait_n(5); dack_n = 1'b1;
        wait_n(3);
    endtask

    // ctl, ia, value
    localparam logic [38:0] VEC [6] = '{
        {1'b1, 6'd3,  32'hDEAD_BEEF},
        {1'b1, 6'd63, 32'h0000_0001},
        {1'b0, 6'd7,  32'hCAFE_F00D},
        {1'b0, 6'd40, 32'h8000_0000},
        {1'b1, 6'd0,  32'h1234_5678},
        {1'b0, 6'd62, 32'hFFFF_0000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [31:0] r;
        int t0;
        wait_n(4);
        // R1: reset state
        check("R1 rdata at reset", rdata, 32'h0);
        check("R1 no take at reset", {31'h0, dma_out_take}, 32'h0);
        check("R1 no in_valid at reset", {31'h0, dma_in_valid}, 32'h0);
        rst_n = 1'b1;
        wait_n(3);
        bus_read(4'h0, r);
        check("R1 pointer zero", r, 32'h0);

        // R3/R4: table of window write, pointer readback, window readback
        for (int i = 0; i < 6; i++) begin
            logic [5:0]  ia;
            logic [31:0] v;
            ctl_wide = VEC[i][38];
            ia = VEC[i][37:32];
            v  = VEC[i][31:0];
            set_ia(ia);
            win_write(v);
            bus_read(4'h0, r);
            check("R3 pointer after write", r, ia_bus(ctl_wide, ia + 6'd1));
            set_ia(ia);
            win_read(r);
            check("R3 R4 window readback", r, v);
        end

        // R3: burst over consecutive registers with a single pointer write
        ctl_wide = 1'b1;
        set_ia(6'd10);
        for (int k = 0; k < 3; k++) win_write(32'hA5A5_0000 + 32'(k));
        set_ia(6'd10);
        for (int k = 0; k < 3; k++) begin
            win_read(r);
            check("R3 burst readback", r, 32'hA5A5_0000 + 32'(k));
        end

        // R2: unmapped locations
        set_ia(6'd20);
        bus_write(4'h5, 32'h0000_0033);
        bus_write(4'hF, 32'hFFFF_FFFF);
        bus_read(4'h0, r);
        check("R2 pointer kept after unmapped write", r, 32'd20);
        bus_read(4'h7, r);
        check("R2 unmapped read zero", r, 32'h0);
        win_read(r);
        check("R2 entry 20 untouched", r, 32'h0);

        // R5: data changed while the strobe is held wins
        set_ia(6'd30);
        @(negedge clk);
        addr = 4'h1; wdata = 32'h1111_1111; cs_n = 1'b0;
        wait_n(2); wr_n = 1'b0;
        wait_n(4); wdata = 32'h2222_2222;
        wait_n(2); wr_n = 1'b1;
        wait_n(5); cs_n = 1'b1;
        wait_n(3);
        set_ia(6'd30);
        win_read(r);
        check("R5 value at release", r, 32'h2222_2222);

        // R6: outbound 8-bit beats, normal strobes
        flyby = 1'b0; data_size = 2'd0;
        dma_out_word = 32'hA1B2_C3D4;
        t0 = takes;
        dma_beat(1'b0, 32'h0, r); check("R6 byte0", r, 32'hA100_0000);
        dma_beat(1'b0, 32'h0, r); check("R6 byte1", r, 32'hB200_0000);
        dma_beat(1'b0, 32'h0, r); check("R6 byte2", r, 32'hC300_0000);
        check("R6 no take mid word", 32'(takes - t0), 32'd0);
        dma_beat(1'b0, 32'h0, r); check("R6 byte3", r, 32'hD400_0000);
        check("R6 one take per word", 32'(takes - t0), 32'd1);

        // R6: outbound 16-bit and 32-bit
        data_size = 2'd1; dma_out_word = 32'h0BAD_F00D;
        dma_beat(1'b0, 32'h0, r); check("R6 half0", r, 32'h0BAD_0000);
        dma_beat(1'b0, 32'h0, r); check("R6 half1", r, 32'hF00D_0000);
        data_size = 2'd3; dma_out_word = 32'h7654_3210;
        dma_beat(1'b0, 32'h0, r); check("R6 full word size 3", r, 32'h7654_3210);

        // R6: inbound 16-bit assembly
        data_size = 2'd1; t0 = ins;
        dma_beat(1'b1, 32'h1234_0000, r);
        check("R6 no in_valid mid word", 32'(ins - t0), 32'd0);
        dma_beat(1'b1, 32'h5678_0000, r);
        check("R6 inbound count", 32'(ins - t0), 32'd1);
        check("R6 inbound word", in_last, 32'h1234_5678);

        // R7: fly-by swaps stream strobes
        flyby = 1'b1; data_size = 2'd2;
        dma_out_word = 32'hFEED_BEEF; t0 = takes;
        dma_beat(1'b1, 32'h0, r);
        check("R7 flyby write pin reads", r, 32'hFEED_BEEF);
        check("R7 flyby take", 32'(takes - t0), 32'd1);
        t0 = ins;
        dma_beat(1'b0, 32'hC0DE_0001, r);
        check("R7 flyby read pin writes", in_last, 32'hC0DE_0001);
        check("R7 flyby inbound count", 32'(ins - t0), 32'd1);
        // R7: register access keeps normal meaning under fly-by
        set_ia(6'd44);
        bus_read(4'h0, r);
        check("R7 register path under flyby", r, 32'd44);
        flyby = 1'b0;

        // R8: both selects held on a write strobe
        t0 = ins;
        @(negedge clk);
        addr = 4'h0; wdata = 32'h0000_0005; cs_n = 1'b0; dack_n = 1'b0;
        wait_n(2); wr_n = 1'b0;
        wait_n(5); wr_n = 1'b1;
        wait_n(5); cs_n = 1'b1; dack_n = 1'b1;
        wait_n(3);
        check("R8 stream served", in_last, 32'h0000_0005);
        check("R8 stream count", 32'(ins - t0), 32'd1);
        bus_read(4'h0, r);
        check("R8 pointer untouched", r, 32'd44);

        report();
        $finish;
    end

endmodule